// File: doc/BRIEF.md
# Zero-Terminated One-Shot with Gate Steering

This block times the switching pulse of a resonant power converter controller and routes it to two gate-drive outputs. A trigger from an external frequency source starts a pulse. The pulse ends at the earlier of two events: a synchronous zero-crossing indication arriving once a programmable blanking count has elapsed, or a programmable maximum count being reached. Because the zero indication is ignored during blanking, the blanking count sets the shortest pulse. A typical setup uses a maximum of about four times the blanking value.

A steering stage maps the pulse onto gate outputs A and B. It has four static configurations. In the alternating configurations, successive pulses go to A and B in turn. In the parallel configurations, both outputs carry the same waveform. In either case the pulse can define the conduction time (on-time) or the dead time (off-time). An inhibit input forces both gates low at once and aborts any pulse in progress. The steering configuration can change only while the block is inhibited.

Top module: `qr_pulse_steer`

## Requirements
- R1: While reset is asserted, both gates are low. Reset leaves the block idle, with the alternating on-time configuration selected and the next pulse destined for A.
- R2: A trigger sampled high at a clock edge while idle and not inhibited makes the pulse start in the following cycle. Without zero termination, the pulse lasts exactly `max_cnt_i` cycles. A value of 0 counts as 1. The maximum wins when it is below the blanking count.
- R3: The zero input ends the pulse after its k-th cycle, where k is the first pulse cycle that has k >= `blank_cnt_i` and `zero_i` high. A zero indication in earlier pulse cycles is ignored.
- R4: Alternating on-time (mode 2'b00): each pulse appears on exactly one gate and the other stays low. Pulses go A, B, A, … starting from A.
- R5: Alternating off-time (mode 2'b01): the gates are two non-overlapping levels. A is high while idle before the first pulse. Each pulse is a dead interval with both gates low, after which the other gate takes over.
- R6: Parallel on-time (mode 2'b10): A and B both equal the pulse.
- R7: Parallel off-time (mode 2'b11): A and B both equal the inverted pulse.
- R8: In any cycle where `inhibit_i` is high, both gates are low in that same cycle. An inhibit sampled at a clock edge aborts the pulse and returns the next pulse to gate A.
- R9: A trigger arriving while a pulse is active has no effect on that pulse. The limits are captured when the pulse starts.
- R10: `mode_i` (bit 1 = parallel, bit 0 = off-time) is captured at every clock edge where `inhibit_i` is high. It is ignored at all other edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inhibit_i | input | 1 | Forces gates low, aborts pulse, loads mode |
| mode_i | input | 2 | Steering configuration, bit 1 parallel, bit 0 off-time |
| trig_i | input | 1 | Pulse start request from the frequency source |
| zero_i | input | 1 | Synchronous zero-crossing indication |
| blank_cnt_i | input | CNT_W | Blanking count (minimum pulse cycles) |
| max_cnt_i | input | CNT_W | Maximum pulse cycles |
| gate_a_o | output | 1 | Gate drive A |
| gate_b_o | output | 1 | Gate drive B |

## Verification
Several properties are checked on every cycle against an independent run counter:
- inhibit forces both gates low;
- the alternating configurations never drive both gates high together;
- the parallel configurations always drive identical gates;
- no pulse outlasts its captured maximum;
- no pulse that ends without inhibit is shorter than its blanking floor.

Only the bench scenarios can show the remaining behaviour. That covers the exact width after a zero indication, the A/B ordering across pulses, and the return of the next pulse to A after inhibit. It also covers a trigger landing inside an active pulse and a mode change attempted while not inhibited.

// File: rtl/qrps_pkg.sv
`timescale 1ns/1ps
package qrps_pkg;

    // Bit 1 selects parallel gates, bit 0 selects the pulse as dead time.
    typedef enum logic [1:0] {
        STEER_ALT_ON  = 2'b00,
        STEER_ALT_OFF = 2'b01,
        STEER_PAR_ON  = 2'b10,
        STEER_PAR_OFF = 2'b11
    } steer_mode_e;

    function automatic logic mode_is_parallel(input steer_mode_e m);
        return m[1];
    endfunction

    function automatic logic mode_is_offtime(input steer_mode_e m);
        return m[0];
    endfunction

endpackage

// File: rtl/qrps_oneshot.sv
`timescale 1ns/1ps
module qrps_oneshot #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inhibit_i,
    input  logic             trig_i,
    input  logic             zero_i,
    input  logic [CNT_W-1:0] blank_i,
    input  logic [CNT_W-1:0] max_i,
    output logic             pulse_o,
    output logic             done_o
);

    localparam logic [CNT_W-1:0] FIRST_CYCLE = CNT_W'(1);

    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] elapsed;
        logic [CNT_W-1:0] blank;
        logic [CNT_W-1:0] limit;
    } os_state_t;

    os_state_t s_d, s_q;
    logic      end_by_max;
    logic      end_by_zero;
    logic      done_d;

    always_comb begin
        s_d         = s_q;
        done_d      = 1'b0;
        end_by_max  = (s_q.elapsed >= s_q.limit);
        end_by_zero = zero_i && (s_q.elapsed >= s_q.blank);
        if (inhibit_i) begin
            s_d.active  = 1'b0;
            s_d.elapsed = '0;
        end else if (s_q.active) begin
            if (end_by_max || end_by_zero) begin
                s_d.active = 1'b0;
                done_d     = 1'b1;
            end else begin
                s_d.elapsed = s_q.elapsed + 1'b1;
            end
        end else if (trig_i) begin
            s_d.active  = 1'b1;
            s_d.elapsed = FIRST_CYCLE;
            s_d.blank   = blank_i;
            s_d.limit   = max_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pulse_o = s_q.active;
    assign done_o  = done_d;

endmodule

// File: rtl/qrps_steer.sv
`timescale 1ns/1ps
module qrps_steer
    import qrps_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       inhibit_i,
    input  logic [1:0] mode_i,
    input  logic       pulse_i,
    input  logic       done_i,
    output logic       gate_a_o,
    output logic       gate_b_o,
    output logic [1:0] mode_o
);

    typedef struct packed {
        steer_mode_e mode;
        logic        on_b;
    } st_state_t;

    st_state_t s_d, s_q;
    logic      shaped;
    logic      raw_a;
    logic      raw_b;

    always_comb begin
        s_d = s_q;
        if (inhibit_i) begin
            s_d.mode = steer_mode_e'(mode_i);
            s_d.on_b = 1'b0;
        end else if (done_i) begin
            s_d.on_b = ~s_q.on_b;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{mode: STEER_ALT_ON, on_b: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        shaped = mode_is_offtime(s_q.mode) ? ~pulse_i : pulse_i;
        if (mode_is_parallel(s_q.mode)) begin
            raw_a = shaped;
            raw_b = shaped;
        end else begin
            raw_a = shaped & ~s_q.on_b;
            raw_b = shaped &  s_q.on_b;
        end
    end

    assign gate_a_o = raw_a & ~inhibit_i;
    assign gate_b_o = raw_b & ~inhibit_i;
    assign mode_o   = s_q.mode;

endmodule

// File: rtl/qr_pulse_steer.sv
`timescale 1ns/1ps
module qr_pulse_steer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inhibit_i,
    input  logic [1:0]       mode_i,
    input  logic             trig_i,
    input  logic             zero_i,
    input  logic [CNT_W-1:0] blank_cnt_i,
    input  logic [CNT_W-1:0] max_cnt_i,
    output logic             gate_a_o,
    output logic             gate_b_o
);

    logic       pulse_w;
    logic       done_w;
    logic [1:0] mode_w;

    qrps_oneshot #(.CNT_W(CNT_W)) u_oneshot (
        .clk       (clk),
        .rst_n     (rst_n),
        .inhibit_i (inhibit_i),
        .trig_i    (trig_i),
        .zero_i    (zero_i),
        .blank_i   (blank_cnt_i),
        .max_i     (max_cnt_i),
        .pulse_o   (pulse_w),
        .done_o    (done_w)
    );

    qrps_steer u_steer (
        .clk       (clk),
        .rst_n     (rst_n),
        .inhibit_i (inhibit_i),
        .mode_i    (mode_i),
        .pulse_i   (pulse_w),
        .done_i    (done_w),
        .gate_a_o  (gate_a_o),
        .gate_b_o  (gate_b_o),
        .mode_o    (mode_w)
    );

endmodule

// File: rtl/qrps_checker.sv
`timescale 1ns/1ps
module qrps_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             inhibit_i,
    input logic [CNT_W-1:0] blank_i,
    input logic [CNT_W-1:0] max_i,
    input logic             pulse,
    input logic [1:0]       mode,
    input logic             gate_a,
    input logic             gate_b
);

    logic [CNT_W:0]   run_q;
    logic [CNT_W-1:0] lat_blank;
    logic [CNT_W-1:0] lat_max;
    logic [CNT_W:0]   eff_max;
    logic [CNT_W:0]   floor_w;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q     <= '0;
            lat_blank <= '0;
            lat_max   <= '0;
        end else begin
            run_q <= pulse ? run_q + 1'b1 : '0;
            if (!pulse) begin
                lat_blank <= blank_i;
                lat_max   <= max_i;
            end
        end
    end

    assign eff_max = (lat_max == '0) ? (CNT_W+1)'(1) : {1'b0, lat_max};
    assign floor_w = ({1'b0, lat_blank} < eff_max) ? {1'b0, lat_blank} : eff_max;

    p_gates_low_inhibit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit_i |-> (!gate_a && !gate_b));

    // Covers R5 as well: alternating gates never overlap.
    p_alt_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !mode[1] |-> !(gate_a && gate_b));

    // Covers R7 as well: parallel gates always match.
    p_par_equal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mode[1] |-> (gate_a == gate_b));

    p_width_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> (run_q < eff_max));

    p_width_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!pulse && (run_q != '0) && !$past(inhibit_i)) |-> (run_q >= floor_w));

endmodule

bind qr_pulse_steer qrps_checker #(.CNT_W(CNT_W)) u_qrps_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .inhibit_i (inhibit_i),
    .blank_i   (blank_cnt_i),
    .max_i     (max_cnt_i),
    .pulse     (pulse_w),
    .mode      (mode_w),
    .gate_a    (gate_a_o),
    .gate_b    (gate_b_o)
);

// File: tb/test_qr_pulse_steer.sv
`timescale 1ns/1ps
module test_qr_pulse_steer;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 8;

    logic         clk;
    logic         rst_n;
    logic         inhibit;
    logic [1:0]   mode_in;
    logic         trig;
    logic         zero;
    logic [W-1:0] blank_cnt;
    logic [W-1:0] max_cnt;
    logic         gate_a;
    logic         gate_b;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    int na, nb;

    // behavioural reference state
    int m_busy, m_age, m_floor, m_cap, m_side, m_cfg;

    qr_pulse_steer #(.CNT_W(W)) i_qr_pulse_steer (
        .clk         (clk),
        .rst_n       (rst_n),
        .inhibit_i   (inhibit),
        .mode_i      (mode_in),
        .trig_i      (trig),
        .zero_i      (zero),
        .blank_cnt_i (blank_cnt),
        .max_cnt_i   (max_cnt),
        .gate_a_o    (gate_a),
        .gate_b_o    (gate_b)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_age = 0; m_side = 0; m_cfg = 0; m_floor = 0; m_cap = 0;
        end else if (inhibit) begin
            m_busy = 0; m_age = 0; m_side = 0; m_cfg = int'(mode_in);
        end else if (m_busy != 0) begin
            if (m_age >= ((m_cap < 1) ? 1 : m_cap) || (zero && m_age >= m_floor)) begin
                m_busy = 0;
                m_side = 1 - m_side;
            end else begin
                m_age = m_age + 1;
            end
        end else if (trig) begin
            m_busy = 1; m_age = 1; m_floor = int'(blank_cnt); m_cap = int'(max_cnt);
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            int ea, eb, lvl;
            string tag;
            lvl = (m_cfg % 2 == 1) ? 1 - m_busy : m_busy;
            if (inhibit) begin
                ea = 0; eb = 0; tag = "R8";
            end else if (m_cfg >= 2) begin
                ea = lvl; eb = lvl; tag = (m_cfg == 3) ? "R7" : "R6";
            end else begin
                ea = (m_side == 0) ? lvl : 0;
                eb = (m_side == 1) ? lvl : 0;
                tag = (m_cfg == 1) ? "R5" : "R4";
            end
            checks++;
            if (int'(gate_a) != ea || int'(gate_b) != eb) begin
                errors++;
                $display("FAIL %s model a=%0d b=%0d expected a=%0d b=%0d at %0t",
                         tag, gate_a, gate_b, ea, eb, $time);
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic set_mode(input logic [1:0] m);
        @(posedge clk) #1; inhibit = 1'b1; mode_in = m;
        @(posedge clk) #1; inhibit = 1'b0;
    endtask

    // Fires one trigger and counts high cycles of each gate over 40 cycles.
    task automatic fire(input int b, input int m, input logic z, input int retrig);
        blank_cnt = W'(b); max_cnt = W'(m); zero = z;
        @(posedge clk) #1; trig = 1'b1;
        na = 0; nb = 0;
        for (int i = 0; i < 40; i++) begin
            @(posedge clk) #1; trig = (i == retrig);
            @(negedge clk);
            na += int'(gate_a);
            nb += int'(gate_b);
        end
        @(posedge clk) #1; trig = 1'b0; zero = 1'b0;
    endtask

    initial begin
        rst_n = 0; inhibit = 0; mode_in = 0; trig = 0; zero = 0;
        blank_cnt = '0; max_cnt = '0;
        repeat (3) @(negedge clk);
        chk("R1 gate_a in reset", int'(gate_a), 0);
        chk("R1 gate_b in reset", int'(gate_b), 0);
        @(posedge clk) #1; rst_n = 1;
        @(negedge clk);
        chk("R1 idle a after reset", int'(gate_a), 0);

        set_mode(2'b00);
        fire(3, 8, 1'b0, -1);
        chk("R2 max width on A", na, 8);  chk("R4 first pulse B idle", nb, 0);
        fire(3, 8, 1'b0, -1);
        chk("R4 second pulse on B", nb, 8); chk("R4 A idle", na, 0);
        fire(5, 20, 1'b1, -1);
        chk("R3 zero blanked to floor", na, 5);
        fire(9, 4, 1'b1, -1);
        chk("R2 max below blank wins", nb, 4);
        fire(0, 0, 1'b0, -1);
        chk("R2 zero max counts as one", na, 1);
        fire(3, 10, 1'b0, 3);
        chk("R9 retrigger ignored", nb, 10); chk("R9 A idle", na, 0);

        mode_in = 2'b11;
        fire(3, 6, 1'b0, -1);
        chk("R10 mode not loaded without inhibit", na, 6);
        chk("R10 B idle", nb, 0);

        mode_in = 2'b00;
        blank_cnt = W'(3); max_cnt = W'(20);
        @(posedge clk) #1; trig = 1'b1;
        @(posedge clk) #1; trig = 1'b0;
        @(negedge clk);
        chk("R4 pulse on B before abort", int'(gate_b), 1);
        @(posedge clk) #1; inhibit = 1'b1;
        @(negedge clk);
        chk("R8 a low under inhibit", int'(gate_a), 0);
        chk("R8 b low under inhibit", int'(gate_b), 0);
        @(posedge clk) #1; inhibit = 1'b0;
        @(negedge clk);
        chk("R8 pulse aborted", int'(gate_b), 0);
        fire(3, 5, 1'b0, -1);
        chk("R8 next pulse back on A", na, 5);

        set_mode(2'b01);
        @(negedge clk);
        chk("R5 A high idle", int'(gate_a), 1);
        chk("R5 B low idle", int'(gate_b), 0);
        fire(3, 7, 1'b0, -1);
        chk("R5 A low after dead time", na, 0);
        chk("R5 B takes over", nb, 33);

        set_mode(2'b10);
        fire(3, 6, 1'b0, -1);
        chk("R6 A equals pulse", na, 6); chk("R6 B equals pulse", nb, 6);

        set_mode(2'b11);
        fire(4, 6, 1'b1, -1);
        chk("R7 A inverted pulse", na, 36); chk("R7 B inverted pulse", nb, 36);
        @(posedge clk) #1; inhibit = 1'b1;
        @(negedge clk);
        chk("R8 par-off a low", int'(gate_a), 0);
        chk("R8 par-off b low", int'(gate_b), 0);
        @(posedge clk) #1; inhibit = 1'b0;

        // continuous triggers with scattered zero indications, model-checked
        set_mode(2'b00);
        blank_cnt = W'(2); max_cnt = W'(6);
        for (int i = 0; i < 80; i++) begin
            @(posedge clk) #1; trig = 1'b1; zero = ((i % 5) == 3);
        end
        @(posedge clk) #1; trig = 1'b0; zero = 1'b0;
        repeat (10) @(posedge clk);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule